// File: doc/BRIEF.md
# Sleep Mode Entry/Exit Controller

This controller sequences a low-power sleep state for a synchronous memory interface. It takes a sleep request that is asynchronous to the clock and passes it through a synchronizer. It then steps through a fixed sequence: entry, sleep, exit and a recovery window, and after that it returns to normal operation. Each transitional phase has a fixed length in clock cycles. While the controller is not fully awake, it blocks command acceptance and keeps the data drivers off.

An access that is still pending while entry runs is reported as cancelled. A select or address strobe seen during the recovery window is ignored and raises a protocol-error pulse. A sleep request that arrives while the device is selected also raises that pulse. Independently of sleep, the data bus drivers stay off during any write cycle, whatever the output enable says.

The interface carries no data stream, so all pins are plain control and status levels. No pin uses a valid/ready handshake and nothing applies back-pressure.

Top module: `sleep_ctrl`

## Requirements
- R1: After reset, `pwr_state_o` reads 0 and `asleep_o`, `proto_err_o`, `cmd_go_o` and `acc_cancel_o` are low. The state encoding is: awake 0, entering 1, asleep 2, exiting 3, recovery 4.
- R2: The request passes through two synchronizer flops. If it is raised before clock edge 1, the state still reads awake after edges 1 and 2 and first reads entering after edge 3.
- R3: The entering state lasts exactly two cycles and is then followed by asleep. It always runs to completion, even if the request drops during entry.
- R4: The asleep state holds while the synchronized request stays high. When the synchronized request drops, the state becomes exiting on the next edge and stays there for exactly two cycles.
- R5: After exiting, the recovery state lasts exactly two cycles and then returns to awake.
- R6: `cmd_go_o` equals `chip_sel_i & (addr_strobe_a_i | addr_strobe_b_i)` only in the awake state. In every other state it is 0.
- R7: `acc_cancel_o` is high in every entering cycle in which `access_pend_i` is high. It is low at all other times.
- R8: `drv_en_o` equals `out_en_i & ~write_cycle_i` in the awake state and is 0 in every other state. A write cycle always turns the drivers off.
- R9: If `chip_sel_i` or either strobe is high in a recovery cycle, `proto_err_o` is high for the cycle that follows. The command is not accepted.
- R10: If the synchronized request is high while the state is awake and `chip_sel_i` is high, `proto_err_o` is high for the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sleep_req_i | input | 1 | Asynchronous sleep request, high = sleep |
| chip_sel_i | input | 1 | Chip select, active high |
| addr_strobe_a_i | input | 1 | First address strobe, active high |
| addr_strobe_b_i | input | 1 | Second address strobe, active high |
| write_cycle_i | input | 1 | A write cycle is detected |
| out_en_i | input | 1 | Output enable request |
| access_pend_i | input | 1 | An access is still in flight |
| cmd_go_o | output | 1 | Command accepted this cycle |
| drv_en_o | output | 1 | Data bus driver enable |
| acc_cancel_o | output | 1 | Pending access is invalidated |
| asleep_o | output | 1 | Sleep state reached |
| pwr_state_o | output | 3 | Current phase code |
| proto_err_o | output | 1 | Protocol violation pulse |

## Verification
The assertions assume that reset is asserted at the start. They also assume that every control input holds a known level at each rising edge. The synchronizer's metastability is not modelled, so the properties only reason about the request as the second flop presents it. The bench changes every input only on the falling edge, which keeps the request clean and stable through both synchronizer stages. It holds each request level long enough for the phase sequence under test to play out.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [2:0] {
    PS_AWAKE   = 3'd0,
    PS_ENTER   = 3'd1,
    PS_ASLEEP  = 3'd2,
    PS_EXIT    = 3'd3,
    PS_RECOVER = 3'd4
  } pwr_state_t;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
#(
  parameter int ENTER_CYC = 2,
  parameter int EXIT_CYC  = 2,
  parameter int RECOV_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_s,
  input  logic       sel,
  input  logic       any_cmd,
  output pwr_state_t state,
  output logic       proto_err
);
  localparam int MAXC1 = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int MAXC  = (MAXC1 > RECOV_CYC) ? MAXC1 : RECOV_CYC;
  localparam int CW    = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] ENTER_LAST = CW'(ENTER_CYC - 1);
  localparam logic [CW-1:0] EXIT_LAST  = CW'(EXIT_CYC - 1);
  localparam logic [CW-1:0] RECOV_LAST = CW'(RECOV_CYC - 1);

  pwr_state_t   nxt;
  logic [CW-1:0] cnt;
  logic          err_nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      PS_AWAKE:   if (req_s)              nxt = PS_ENTER;
      PS_ENTER:   if (cnt == ENTER_LAST)  nxt = PS_ASLEEP;
      PS_ASLEEP:  if (!req_s)             nxt = PS_EXIT;
      PS_EXIT:    if (cnt == EXIT_LAST)   nxt = PS_RECOVER;
      PS_RECOVER: if (cnt == RECOV_LAST)  nxt = PS_AWAKE;
      default:                            nxt = PS_AWAKE;
    endcase
  end

  always_comb begin
    err_nxt = ((state == PS_RECOVER) && any_cmd) ||
              ((state == PS_AWAKE) && req_s && sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PS_AWAKE;
      cnt       <= '0;
      proto_err <= 1'b0;
    end else begin
      state     <= nxt;
      proto_err <= err_nxt;
      if (nxt != state)
        cnt <= '0;
      else if (state == PS_ENTER || state == PS_EXIT || state == PS_RECOVER)
        cnt <= cnt + 1'b1;
    end
  end

  assert_enter_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_ENTER && cnt == '0) |=> (state == PS_ENTER));
  assert_enter_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_ENTER && cnt == ENTER_LAST) |=> (state == PS_ASLEEP));
  assert_sleep_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_ASLEEP) |=> (state == PS_ASLEEP || state == PS_EXIT));
  assert_recov_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_RECOVER && cnt == RECOV_LAST) |=> (state == PS_AWAKE));
endmodule

// File: rtl/slp_gate.sv
module slp_gate
  import slp_pkg::*;
(
  input  pwr_state_t state,
  input  logic       sel,
  input  logic       strobe_a,
  input  logic       strobe_b,
  input  logic       wr,
  input  logic       oe,
  input  logic       pend,
  output logic       cmd_go,
  output logic       drv_en,
  output logic       cancel,
  output logic       asleep
);
  logic awake;

  always_comb begin
    awake  = (state == PS_AWAKE);
    cmd_go = awake && sel && (strobe_a || strobe_b);
    drv_en = awake && oe && !wr;
    cancel = (state == PS_ENTER) && pend;
    asleep = (state == PS_ASLEEP);
  end
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import slp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTER_CYC   = 2,
  parameter int EXIT_CYC    = 2,
  parameter int RECOV_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req_i,
  input  logic       chip_sel_i,
  input  logic       addr_strobe_a_i,
  input  logic       addr_strobe_b_i,
  input  logic       write_cycle_i,
  input  logic       out_en_i,
  input  logic       access_pend_i,
  output logic       cmd_go_o,
  output logic       drv_en_o,
  output logic       acc_cancel_o,
  output logic       asleep_o,
  output logic [2:0] pwr_state_o,
  output logic       proto_err_o
);
  logic       req_s;
  logic       any_cmd;
  pwr_state_t state;

  assign any_cmd = chip_sel_i | addr_strobe_a_i | addr_strobe_b_i;

  slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(sleep_req_i), .q_sync(req_s)
  );

  slp_fsm #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC), .RECOV_CYC(RECOV_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .sel(chip_sel_i),
    .any_cmd(any_cmd), .state(state), .proto_err(proto_err_o)
  );

  slp_gate u_gate (
    .state(state), .sel(chip_sel_i), .strobe_a(addr_strobe_a_i),
    .strobe_b(addr_strobe_b_i), .wr(write_cycle_i), .oe(out_en_i),
    .pend(access_pend_i), .cmd_go(cmd_go_o), .drv_en(drv_en_o),
    .cancel(acc_cancel_o), .asleep(asleep_o)
  );

  assign pwr_state_o = state;

  assert_no_cmd_asleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state_o != 3'd0) |-> !cmd_go_o);
  assert_wr_drv_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    write_cycle_i |-> !drv_en_o);
  assert_recov_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state_o == 3'd4 && any_cmd) |=> proto_err_o);
  assert_cancel_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_cancel_o |-> (pwr_state_o == 3'd1));
endmodule

// File: tb/tb_sleep_ctrl.sv
`timescale 1ns/1ps
module tb_sleep_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, cs = 1'b0, sa = 1'b0, sb = 1'b0, wr = 1'b0, oe = 1'b0, pend = 1'b0;
  logic cmd_go, drv_en, cancel, asleep, perr;
  logic [2:0] st;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sleep_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sleep_req_i(req), .chip_sel_i(cs),
    .addr_strobe_a_i(sa), .addr_strobe_b_i(sb), .write_cycle_i(wr),
    .out_en_i(oe), .access_pend_i(pend), .cmd_go_o(cmd_go), .drv_en_o(drv_en),
    .acc_cancel_o(cancel), .asleep_o(asleep), .pwr_state_o(st), .proto_err_o(perr)
  );

  task automatic chk(input string r, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", r, got, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_entry(int e);
    return (e < 3) ? 0 : (e < 5) ? 1 : 2;
  endfunction
  function automatic int exp_exit(int e);
    return (e < 3) ? 2 : (e < 5) ? 3 : (e < 7) ? 4 : 0;
  endfunction
  function automatic int exp_short(int e);
    return (e < 3) ? 0 : (e < 5) ? 1 : (e < 6) ? 2 : (e < 8) ? 3 : (e < 10) ? 4 : 0;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 state", st, 0);
    chk("R1 asleep", asleep, 0);
    chk("R1 proto_err", perr, 0);
    chk("R1 cmd_go", cmd_go, 0);
    chk("R1 cancel", cancel, 0);
    rst_n = 1'b1;
    tick;

    // R6 R8: sweep of every control combination while awake
    for (int v = 0; v < 32; v++) begin
      {cs, sa, sb, wr, oe} = v[4:0];
      #1;
      chk("R6 cmd_go awake", cmd_go, int'(cs & (sa | sb)));
      chk("R8 drv_en awake", drv_en, int'(oe & ~wr));
      tick;
    end
    {cs, sa, sb, wr, oe} = 5'b0;
    tick;

    // R2 R3 R7: entry with an access pending
    pend = 1'b1;
    req  = 1'b1;
    for (int e = 1; e <= 6; e++) begin
      tick;
      chk("R2/R3 entry state", st, exp_entry(e));
      chk("R7 cancel", cancel, (exp_entry(e) == 1) ? 1 : 0);
      chk("R10 no error deselected", perr, 0);
    end
    pend = 1'b0;
    #1;
    chk("R7 cancel idle", cancel, 0);

    // R6 R8: asleep sweep, nothing accepted, drivers off
    for (int v = 0; v < 32; v++) begin
      {cs, sa, sb, wr, oe} = v[4:0];
      #1;
      chk("R6 cmd_go asleep", cmd_go, 0);
      chk("R8 drv_en asleep", drv_en, 0);
      chk("R4 asleep held", st, 2);
      tick;
    end
    {cs, sa, sb, wr, oe} = 5'b0;
    chk("R4 asleep flag", asleep, 1);

    // R4 R5 R9: exit, recovery, select during recovery
    req = 1'b0;
    for (int e = 1; e <= 7; e++) begin
      tick;
      chk("R4/R5 exit state", st, exp_exit(e));
      chk("R9 proto_err", perr, (e == 6) ? 1 : 0);
      if (e == 5) begin
        cs = 1'b1; sa = 1'b1; oe = 1'b1;
        #1;
        chk("R9 cmd ignored in recovery", cmd_go, 0);
        chk("R8 drv off in recovery", drv_en, 0);
      end
      if (e == 6) begin
        cs = 1'b0; sa = 1'b0; oe = 1'b0;
      end
    end

    // R10 R3: request while selected, request dropped during entry
    cs  = 1'b1;
    req = 1'b1;
    for (int e = 1; e <= 10; e++) begin
      tick;
      chk("R3 short request state", st, exp_short(e));
      chk("R10 proto_err", perr, (e == 3) ? 1 : 0);
      if (e == 3) begin
        cs  = 1'b0;
        req = 1'b0;
      end
    end
    sa = 1'b1; cs = 1'b1;
    #1;
    chk("R6 cmd_go after return", cmd_go, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule